// File: doc/BRIEF.md
# Four-Channel Dead-Time Generator

The block sits between a timer's compare outputs and the gate drivers of a set of half bridges. Each of its waveform inputs drives two complementary outputs, one high side and one low side. A break, the dead time, is placed after every input transition, and during that break both switches stay off. All channels share one dead time for the high side and one for the low side.

The two shared dead-time values are written through a small write port into holding registers. They take effect only when the timer issues its update strobe, so a new setting never lands in the middle of a period. A per-channel down-counter measures the break. Every waveform input passes through an edge detector. The direction of the edge picks which dead time is loaded. The counters and edge detectors advance only on cycles where the peripheral clock enable is high.

Top module: `dead_time_gen`

## Requirements
- R1: While reset is active, and until the first enabled cycle after reset, every `hs_o` and `ls_o` bit is 0.
- R2: A write (`cfg_we_i`=1) only fills a holding register. Dead times used by the channels do not change until `update_i` is seen.
- R3: `cfg_sel_i`=0 addresses the low-side value and 1 the high-side value. On `update_i`, each side whose holding register was written since the last update is copied to its active value. A side not written keeps its active value. A write in the same cycle as `update_i` lands after the copy and waits for the next strobe.
- R4: When an enabled cycle samples a channel input as 1 where the previous enabled sample was 0, both outputs of that channel are 0 for the next low-side dead time count of enabled cycles. After that, `hs_o`=1 and `ls_o`=0.
- R5: When an enabled cycle samples a falling input, both outputs are 0 for the high-side dead time count of enabled cycles. After that, `ls_o`=1 and `hs_o`=0.
- R6: `hs_o` and `ls_o` of one channel are never 1 together.
- R7: A dead time of 0 inserts no break. The outputs swap in the same cycle that the edge is sampled.
- R8: An input edge sampled while a break is still running restarts the break, using the dead time chosen by the new edge's direction.
- R9: While `clk_en_i` is 0, the counters and edge history hold and the outputs do not change. An input change is detected at the next enabled cycle.
- R10: The channels run independently on the shared settings.
- R11: The full-scale dead time (all ones) gives its full break. After the break the counter rests at zero and the outputs stay steady while the input is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Peripheral clock enable that paces the channels |
| wg_i | input | NUM_CH | Waveform inputs, one per channel |
| cfg_we_i | input | 1 | Write strobe for a dead-time holding register |
| cfg_sel_i | input | 1 | Target side: 0 low side, 1 high side |
| cfg_wdata_i | input | CNT_W | Dead-time value written |
| update_i | input | 1 | Single-cycle strobe that commits the holding registers |
| hs_o | output | NUM_CH | High-side gate drives |
| ls_o | output | NUM_CH | Low-side gate drives |

## Verification
The bench uses the defaults: four channels and an 8-bit counter. With four channels it can drive unlike patterns on neighbouring channels at once, and so check that one shared setting serves them all. With an 8-bit counter, a full-scale break of 255 cycles stays short enough to run to the end. Small dead times of 2 to 5 cycles make room for retriggers inside a break, for pauses of the clock enable in mid-count, and for strobes that arrive together with a write.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dtg_shadow_regs.sv
module dtg_shadow_regs
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  side_e            sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] dt_lo_o,
  output logic [CNT_W-1:0] dt_hi_o
);

  logic [NUM_SIDES-1:0][CNT_W-1:0] act_all;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    logic             pend_q;
    logic             wr_hit;

    assign wr_hit = we_i && (sel_i == side_e'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '0;
        act_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        // commit uses pre-write contents; a same-cycle write stays pending
        if (update_i && pend_q) act_q <= hold_q;
        if (wr_hit) begin
          hold_q <= wdata_i;
          pend_q <= 1'b1;
        end else if (update_i) begin
          pend_q <= 1'b0;
        end
      end
    end

    assign act_all[s] = act_q;
  end

  assign dt_lo_o = act_all[SIDE_LO];
  assign dt_hi_o = act_all[SIDE_HI];

endmodule

// File: rtl/dtg_edge.sv
module dtg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic hist_o,
  output logic chg_o,
  output logic rise_o
);

  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= 1'b0;
    else if (en_i) hist_q <= d_i;
  end

  assign hist_o = hist_q;
  assign chg_o  = d_i ^ hist_q;
  assign rise_o = d_i & ~hist_q;

endmodule

// File: rtl/dtg_channel.sv
module dtg_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wg_i,
  input  logic [CNT_W-1:0] dt_lo_i,
  input  logic [CNT_W-1:0] dt_hi_i,
  output logic             hs_o,
  output logic             ls_o
);

  logic             level;
  logic             chg;
  logic             rise;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             live;

  dtg_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (wg_i),
    .hist_o (level),
    .chg_o  (chg),
    .rise_o (rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en_i) begin
      armed_q <= 1'b1;
      if (chg)               cnt_q <= rise ? dt_lo_i : dt_hi_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // armed_q keeps both sides off between reset and the first enabled cycle
  assign live = armed_q && (cnt_q == '0);
  assign hs_o = live &  level;
  assign ls_o = live & ~level;

endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
  import dtg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [NUM_CH-1:0] wg_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  input  logic              update_i,
  output logic [NUM_CH-1:0] hs_o,
  output logic [NUM_CH-1:0] ls_o
);

  logic [CNT_W-1:0] dt_lo_act;
  logic [CNT_W-1:0] dt_hi_act;

  dtg_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (side_e'(cfg_sel_i)),
    .wdata_i  (cfg_wdata_i),
    .update_i (update_i),
    .dt_lo_o  (dt_lo_act),
    .dt_hi_o  (dt_hi_act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dtg_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (clk_en_i),
      .wg_i    (wg_i[c]),
      .dt_lo_i (dt_lo_act),
      .dt_hi_i (dt_hi_act),
      .hs_o    (hs_o[c]),
      .ls_o    (ls_o[c])
    );
  end

endmodule

// File: rtl/dead_time_gen_chk.sv
module dead_time_gen_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic [NUM_CH-1:0] wg_i,
  input logic              update_i,
  input logic [NUM_CH-1:0] hs_o,
  input logic [NUM_CH-1:0] ls_o,
  input logic [CNT_W-1:0]  dt_lo_act,
  input logic [CNT_W-1:0]  dt_hi_act
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_off_R1: assert (hs_o == '0 && ls_o == '0)
        else $error("outputs not off in reset");
    end
  end

  assert_hold_until_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> ($stable(dt_lo_act) && $stable(dt_hi_act)));

  assert_frozen_without_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(hs_o) && $stable(ls_o)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_o[c] && ls_o[c]));

    assert_hs_follows_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_o[c]) |-> ($past(clk_en_i) && $past(wg_i[c])));

    assert_ls_follows_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_o[c]) |-> ($past(clk_en_i) && !$past(wg_i[c])));
  end

endmodule

bind dead_time_gen dead_time_gen_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_i  (clk_en_i),
  .wg_i      (wg_i),
  .update_i  (update_i),
  .hs_o      (hs_o),
  .ls_o      (ls_o),
  .dt_lo_act (dt_lo_act),
  .dt_hi_act (dt_hi_act)
);

// File: tb/dead_time_gen_bench.sv
module dead_time_gen_bench;
  localparam int NCH = 4;
  localparam int W   = 8;

  typedef struct {
    logic [NCH-1:0] hs;
    logic [NCH-1:0] ls;
    string          tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [NCH-1:0] wg = '0;
  logic           we = 1'b0;
  logic           sel = 1'b0;
  logic [W-1:0]   wd = '0;
  logic           upd = 1'b0;
  logic [NCH-1:0] hs, ls;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];

  // reference state derived from the requirements
  logic [NCH-1:0] m_armed, m_lvl;
  int             m_rem [NCH];
  logic [W-1:0]   m_act_lo, m_act_hi, m_buf_lo, m_buf_hi;
  logic           m_pend_lo, m_pend_hi;

  always #5 clk = ~clk;

  dead_time_gen #(.NUM_CH(NCH), .CNT_W(W)) u_dead_time_gen (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .wg_i(wg),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd), .update_i(upd),
    .hs_o(hs), .ls_o(ls)
  );

  task automatic model_clear();
    m_armed = '0; m_lvl = '0;
    for (int c = 0; c < NCH; c++) m_rem[c] = 0;
    m_act_lo = '0; m_act_hi = '0; m_buf_lo = '0; m_buf_hi = '0;
    m_pend_lo = 1'b0; m_pend_hi = 1'b0;
  endtask

  task automatic step(input logic [NCH-1:0] w, input logic e, input logic wr,
                      input logic s, input logic [W-1:0] d, input logic u,
                      input string tag);
    item_t it;
    @(negedge clk);
    wg = w; en = e; we = wr; sel = s; wd = d; upd = u;
    if (e) begin
      for (int c = 0; c < NCH; c++) begin
        m_armed[c] = 1'b1;
        if (w[c] != m_lvl[c]) begin
          m_rem[c] = w[c] ? int'(m_act_lo) : int'(m_act_hi);
          m_lvl[c] = w[c];
        end else if (m_rem[c] != 0) m_rem[c]--;
      end
    end
    if (u) begin
      if (m_pend_lo) m_act_lo = m_buf_lo;
      if (m_pend_hi) m_act_hi = m_buf_hi;
      m_pend_lo = 1'b0; m_pend_hi = 1'b0;
    end
    if (wr) begin
      if (s) begin m_buf_hi = d; m_pend_hi = 1'b1; end
      else   begin m_buf_lo = d; m_pend_lo = 1'b1; end
    end
    for (int c = 0; c < NCH; c++) begin
      it.hs[c] = m_armed[c] && m_rem[c] == 0 &&  m_lvl[c];
      it.ls[c] = m_armed[c] && m_rem[c] == 0 && !m_lvl[c];
    end
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic run(input logic [NCH-1:0] w, input int n, input string tag);
    for (int i = 0; i < n; i++) step(w, 1'b1, 1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic write_dt(input logic s, input logic [W-1:0] d, input logic [NCH-1:0] w,
                          input string tag);
    step(w, 1'b1, 1'b1, s, d, 1'b0, tag);
  endtask

  task automatic commit(input logic [NCH-1:0] w, input string tag);
    step(w, 1'b1, 1'b0, 1'b0, '0, 1'b1, tag);
  endtask

  task automatic check_off(input string tag);
    checks++;
    if (hs !== '0 || ls !== '0) begin
      errors++;
      $display("FAIL %s hs=%b ls=%b expected hs=%b ls=%b", tag, hs, ls, 4'b0, 4'b0);
    end
  endtask

  // monitor: compares after each active edge, clear of the edge itself
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (hs !== it.hs || ls !== it.ls) begin
          errors++;
          $display("FAIL %s hs=%b ls=%b expected hs=%b ls=%b", it.tag, hs, ls, it.hs, it.ls);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog hs=%b ls=%b expected run to finish", hs, ls);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #2 check_off("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    #12 check_off("R1 before first enable");

    // R7: zero dead time after reset, no break
    run(4'b0000, 2, "R7 idle low");
    run(4'b0001, 2, "R7 rise no gap");
    run(4'b0000, 2, "R7 fall no gap");

    // R2: written values wait for the strobe
    write_dt(1'b0, 8'd3, 4'b0000, "R2 write lo");
    write_dt(1'b1, 8'd5, 4'b0000, "R2 write hi");
    run(4'b0001, 2, "R2 still zero gap");
    run(4'b0000, 2, "R2 still zero gap");

    commit(4'b0000, "R3 commit");
    // R4 / R5
    run(4'b0001, 6, "R4 rise break lo");
    run(4'b0000, 8, "R5 fall break hi");

    // R3: single-side commit keeps the other side
    write_dt(1'b0, 8'd2, 4'b0000, "R3 write lo only");
    commit(4'b0000, "R3 commit lo only");
    run(4'b0001, 4, "R3 new lo");
    run(4'b0000, 7, "R3 hi kept");

    // R3: write together with strobe waits for next strobe
    write_dt(1'b1, 8'd4, 4'b0000, "R3 write hi");
    step(4'b0000, 1'b1, 1'b1, 1'b1, 8'd1, 1'b1, "R3 write with strobe");
    run(4'b0001, 4, "R3 lo");
    run(4'b0000, 6, "R3 hi from older write");
    commit(4'b0000, "R3 second commit");
    run(4'b0001, 4, "R3 lo");
    run(4'b0000, 4, "R3 hi late write");

    // R8: retrigger inside a break
    run(4'b0001, 1, "R8 rise");
    run(4'b0000, 1, "R8 fall mid break");
    run(4'b0001, 1, "R8 rise mid break");
    run(4'b0001, 5, "R8 settle");

    // R9: enable pauses
    run(4'b0000, 1, "R9 fall");
    for (int i = 0; i < 3; i++) step(4'b0000, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R9 paused count");
    run(4'b0000, 3, "R9 resume");
    for (int i = 0; i < 2; i++) step(4'b0001, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R9 change while paused");
    run(4'b0001, 4, "R9 change seen");

    // R10: unlike patterns across channels
    run(4'b1010, 3, "R10 mixed");
    run(4'b0110, 3, "R10 mixed");
    run(4'b1100, 5, "R10 mixed");
    run(4'b0011, 6, "R10 mixed");

    // R11: full scale break and rest at zero
    write_dt(1'b0, 8'd255, 4'b0011, "R11 write full");
    commit(4'b0011, "R11 commit");
    run(4'b0000, 6, "R11 prep");
    run(4'b1111, 262, "R11 full break then hold");

    // R1: reset mid run
    wait (exp_q.size() == 0);
    @(negedge clk) rst_n = 1'b0;
    #1 check_off("R1 mid run reset");
    model_clear();
    @(negedge clk) rst_n = 1'b1;
    run(4'b0101, 3, "R1 after reset zero dt");

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule